// File: doc/BRIEF.md
# Single-Bit Operation Unit

This unit carries out one-bit operations for a small processor core. Each operation arrives as a code together with the value of the operand bit, which has already been fetched, and a condition result that has already been evaluated. The unit keeps the carry and zero flags in its own register. Logic operations use the carry flag as a one-bit accumulator. Test operations place the inverted operand bit in the zero flag. The write-back operations produce the new value of the operand bit and a write enable.

Operations enter on a valid/ready channel. The flags are updated on the clock edge at which an operation is accepted. The write-back result for that operation is held in a single output register and is offered on a second valid/ready channel in the following cycle. While the output register is full and the consumer holds `res_ready` low, `in_ready` is low. In that state no new operation is accepted and the flags stay frozen. A result and a new operation can both be transferred on the same edge, so a steady stream runs with no bubbles. Bit addressing, memory access and condition decoding are handled outside the unit.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted and after it is released, `flag_c` and `flag_z` are 0 and `res_valid` is 0.
- R2: `in_ready` equals `!res_valid || res_ready`. An operation accepted on an edge makes `res_valid` high after that edge. While `res_valid` is high and `res_ready` is low, `res_valid`, `res_wr_en` and `res_wr_bit` hold their values.
- R3: Codes 0 and 1 set C to C AND bit and to C AND (NOT bit) respectively. Z is unchanged and `res_wr_en` is 0.
- R4: Codes 2 and 3 set C to C OR bit and to C OR (NOT bit) respectively. Z is unchanged and `res_wr_en` is 0.
- R5: Codes 4 and 5 set C to C XOR bit and to C XOR (NOT bit) respectively. Z is unchanged and `res_wr_en` is 0.
- R6: Code 6 sets Z to NOT bit and C to bit. Code 7 sets both Z and C to NOT bit. Neither code writes the bit.
- R7: Codes 8 and 9 set Z to NOT bit and C to the original bit. Code 8 then writes 0 to the bit and code 9 writes 1, with `res_wr_en` set to 1.
- R8: Code 10 writes 1, code 11 writes 0 and code 12 writes NOT bit. All three leave both flags unchanged.
- R9: Code 13 writes the value of `in_cond` to the bit and leaves both flags unchanged.
- R10: Codes 14 and 15 produce a result with `res_wr_en` at 0 and leave both flags unchanged.
- R11: The flags change only on an edge where `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| in_op | input | 4 | Operation code |
| in_bit | input | 1 | Current value of the operand bit |
| in_cond | input | 1 | Evaluated condition, used by the conditional move |
| res_valid | output | 1 | A write-back result is offered |
| res_ready | input | 1 | The consumer takes the result |
| res_wr_en | output | 1 | The operand bit is to be written |
| res_wr_bit | output | 1 | New value for the operand bit |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
On every cycle, the assertions check that the flags hold between accepted operations and that a stalled result stays unchanged. They also check the flag and write-back effects of the accumulate, test, test-and-modify, conditional-move and reserved codes on the cycle after acceptance. A chain of accumulate operations is only shown to give the right result by the bench's scoreboard, which carries a reference flag state across long random streams. The same applies to the interaction between back-pressure from the consumer and the ordering of the flag updates.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_CAND  = 4'd0,
    OP_CANDN = 4'd1,
    OP_COR   = 4'd2,
    OP_CORN  = 4'd3,
    OP_CXOR  = 4'd4,
    OP_CXORN = 4'd5,
    OP_TST   = 4'd6,
    OP_TSTN  = 4'd7,
    OP_TCLR  = 4'd8,
    OP_TSET  = 4'd9,
    OP_SET   = 4'd10,
    OP_CLR   = 4'd11,
    OP_INV   = 4'd12,
    OP_CMOV  = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } bop_e;

  typedef struct packed {
    logic c;
    logic z;
  } flags_t;

  typedef struct packed {
    logic wr_en;
    logic wr_bit;
  } wb_t;

endpackage

// File: rtl/bitop_flag_next.sv
module bitop_flag_next
  import bitop_pkg::*;
(
  input  bop_e   op,
  input  logic   bit_v,
  input  flags_t cur,
  output flags_t nxt
);
  logic operand;

  // Inverted-operand variants use the odd codes of the accumulate group.
  assign operand = op[0] ? ~bit_v : bit_v;

  always_comb begin
    nxt = cur;
    unique case (op)
      OP_CAND, OP_CANDN: nxt.c = cur.c & operand;
      OP_COR,  OP_CORN:  nxt.c = cur.c | operand;
      OP_CXOR, OP_CXORN: nxt.c = cur.c ^ operand;
      OP_TST, OP_TCLR, OP_TSET: begin
        nxt.z = ~bit_v;
        nxt.c = bit_v;
      end
      OP_TSTN: begin
        nxt.z = ~bit_v;
        nxt.c = ~bit_v;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/bitop_wb_gen.sv
module bitop_wb_gen
  import bitop_pkg::*;
(
  input  bop_e op,
  input  logic bit_v,
  input  logic cond,
  output wb_t  wb
);
  always_comb begin
    wb = '0;
    unique case (op)
      OP_TCLR, OP_CLR: wb = '{wr_en: 1'b1, wr_bit: 1'b0};
      OP_TSET, OP_SET: wb = '{wr_en: 1'b1, wr_bit: 1'b1};
      OP_INV:          wb = '{wr_en: 1'b1, wr_bit: ~bit_v};
      OP_CMOV:         wb = '{wr_en: 1'b1, wr_bit: cond};
      default:         wb = '0;
    endcase
  end
endmodule

// File: rtl/bitop_flag_reg.sv
module bitop_flag_reg
  import bitop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t nxt,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= nxt;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R11
endmodule

// File: rtl/bitop_res_stage.sv
module bitop_res_stage
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  wb_t  din,
  input  logic out_ready,
  output logic out_valid,
  output wb_t  dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dout)); // R2
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int OPW = bitop_pkg::OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic           in_bit,
  input  logic           in_cond,
  output logic           res_valid,
  input  logic           res_ready,
  output logic           res_wr_en,
  output logic           res_wr_bit,
  output logic           flag_c,
  output logic           flag_z
);
  localparam logic [OPW-1:0] LAST_ACC = OPW'(5);
  localparam logic [OPW-1:0] LAST_TST = OPW'(7);
  localparam logic [OPW-1:0] FIRST_RSV = OPW'(14);

  bop_e   op;
  flags_t flags_q, flags_d;
  wb_t    wb_d, wb_q;
  logic   accept;

  assign op       = bop_e'(in_op);
  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  bitop_flag_next u_fnext (
    .op(op), .bit_v(in_bit), .cur(flags_q), .nxt(flags_d)
  );

  bitop_wb_gen u_wbgen (
    .op(op), .bit_v(in_bit), .cond(in_cond), .wb(wb_d)
  );

  bitop_flag_reg u_freg (
    .clk(clk), .rst_n(rst_n), .load(accept), .nxt(flags_d), .q(flags_q)
  );

  bitop_res_stage u_res (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(wb_d),
    .out_ready(res_ready), .out_valid(res_valid), .dout(wb_q)
  );

  assign flag_c     = flags_q.c;
  assign flag_z     = flags_q.z;
  assign res_wr_en  = wb_q.wr_en;
  assign res_wr_bit = wb_q.wr_bit;

  AST_ACC_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op <= LAST_ACC |=> flag_z == $past(flag_z) && !res_wr_en); // R3
  AST_AND_INTO_C: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPW'(OP_CAND) |=> flag_c == ($past(flag_c) & $past(in_bit))); // R3
  AST_XORN_INTO_C: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPW'(OP_CXORN) |=> flag_c == ($past(flag_c) ^ !$past(in_bit))); // R5
  AST_TEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPW'(OP_TST) |=> flag_z == !$past(in_bit) && flag_c == $past(in_bit)); // R6
  AST_TEST_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op > LAST_ACC && in_op <= LAST_TST |=> res_valid && !res_wr_en); // R6
  AST_TCLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPW'(OP_TCLR) |=> res_wr_en && !res_wr_bit && flag_c == $past(in_bit)); // R7
  AST_CMOV_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OPW'(OP_CMOV) |=> res_wr_en && res_wr_bit == $past(in_cond)
      && $stable({flag_c, flag_z})); // R9
  AST_RSV_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op >= FIRST_RSV |=> res_valid && !res_wr_en && $stable({flag_c, flag_z})); // R10
endmodule

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_bit = 0, in_cond = 0, res_ready = 1;
  logic [3:0] in_op = 0;
  logic in_ready, res_valid, res_wr_en, res_wr_bit, flag_c, flag_z;
  int checks = 0, errors = 0;
  logic mc = 0, mz = 0;
  logic [7:0] sbq[$];
  logic rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  always #10 clk = ~clk;

  bitop_unit uut (.*);

  function automatic logic [3:0] model(input logic [3:0] op, input logic b, cnd, c, z);
    logic nc, nz, we, wb;
    nc = c; nz = z; we = 0; wb = 0;
    case (op)
      0: nc = c & b;
      1: nc = c & ~b;
      2: nc = c | b;
      3: nc = c | ~b;
      4: nc = c ^ b;
      5: nc = c ^ ~b;
      6: begin nz = ~b; nc = b; end
      7: begin nz = ~b; nc = ~b; end
      8: begin nz = ~b; nc = b; we = 1; wb = 0; end
      9: begin nz = ~b; nc = b; we = 1; wb = 1; end
      10: begin we = 1; wb = 1; end
      11: begin we = 1; wb = 0; end
      12: begin we = 1; wb = ~b; end
      13: begin we = 1; wb = cnd; end
      default: ;
    endcase
    return {nc, nz, we, wb};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 7) return "R6";
    if (op <= 9) return "R7";
    if (op <= 12) return "R8";
    if (op == 13) return "R9";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge; pushes the expected item and offers the op.
  task automatic send(input logic [3:0] op, input logic b, input logic cnd);
    logic [3:0] e;
    e = model(op, b, cnd, mc, mz);
    mc = e[3]; mz = e[2];
    sbq.push_back({op, e});
    in_op = op; in_bit = b; in_cond = cnd; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor: compares each transferred result and the flags it left behind.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (sbq.size() == 0) begin
        chk(0, "R2", {4'h0, flag_c, flag_z, res_wr_en, res_wr_bit}, 8'h00);
      end else begin
        logic [7:0] it;
        logic [3:0] act;
        it = sbq.pop_front();
        act = {flag_c, flag_z, res_wr_en, res_wr_bit};
        chk(act == it[3:0], req_of(it[7:4]), {it[7:4], act}, it);
      end
    end
  end

  // Random back-pressure from the consumer, changed well away from the sampling edge.
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rnd_ready) res_ready <= lfsr[3] | lfsr[7];
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({flag_c, flag_z, res_valid} == 3'b000, "R1", {5'b0, flag_c, flag_z, res_valid}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk({flag_c, flag_z, res_valid} == 3'b000, "R1", {5'b0, flag_c, flag_z, res_valid}, 8'h00);
    chk(in_ready == 1, "R2", {7'b0, in_ready}, 8'h01);

    // Directed sweep over every code, both bit values and both conditions.
    for (int k = 0; k < 64; k++) send(4'(k % 16), k[4], k[5]);
    // Accumulate chains: R3 R4 R5
    send(4'd9, 1, 0); send(4'd0, 1, 0); send(4'd1, 1, 0); send(4'd3, 0, 0);
    send(4'd4, 1, 0); send(4'd5, 1, 0); send(4'd2, 0, 0);
    // R7 then R8 and R9 leave flags intact
    send(4'd8, 0, 0); send(4'd10, 1, 0); send(4'd12, 1, 0); send(4'd13, 0, 1);

    // R2 / R11: stall the output, offer a flag-changing op, flags must freeze.
    @(posedge clk); #1 res_ready = 0;
    @(negedge clk);
    send(4'd9, 0, 0);
    in_op = 4'd4; in_bit = 1; in_cond = 0; in_valid = 1;
    repeat (3) @(negedge clk);
    chk(res_valid == 1, "R2", {7'b0, res_valid}, 8'h01);
    chk(in_ready == 0, "R2", {7'b0, in_ready}, 8'h00);
    chk(res_wr_en && res_wr_bit, "R2", {6'b0, res_wr_en, res_wr_bit}, 8'h03);
    chk({flag_c, flag_z} == {mc, mz}, "R11", {6'b0, flag_c, flag_z}, {6'b0, mc, mz});
    in_valid = 0;
    @(posedge clk); #1 res_ready = 1;
    @(negedge clk);

    // Random stream under random back-pressure.
    rnd_ready = 1;
    for (int n = 0; n < 400; n++) send(lfsr[11:8], lfsr[0], lfsr[5]);
    rnd_ready = 0;
    @(posedge clk); #1 res_ready = 1;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule